// File: doc/BRIEF.md
# Scatter-Gather IDE Bus-Master DMA Engine

This block is the bus-master data mover for a single-channel IDE host. Software writes a small register file: the memory address of a table of 16-byte scatter-gather descriptors, the address of a 128-byte completion line, and a transfer direction. It then sets a start bit. The engine reads the descriptors one after another. It moves 32-bit words between a memory master port and a device-side stream, in either direction, until it has finished the descriptor that carries the end-of-list flag.

Once the last data word has gone to memory, the engine fills the completion line with all-ones words. Software watches that line, not the status register, to learn that every data write has landed. The engine keeps two separate byte counts, one for the device side and one for the memory side, and both can be read back after a transfer. A stop request halts the engine at the next word boundary. A memory error aborts the transfer and leaves a sticky error flag.

Top module: `ide_sg_dma`

## Requirements
- R1: After reset, every register reads 0, `mem_req`, `dev_out_valid` and `dev_in_ready` are low, and the engine issues no memory request while it is inactive.
- R2: Registers are addressed by word index. 0 is timing (storage only). 1 and 2 are the table pointer low and high. 3 is the current memory address. 4 is the memory address high (storage only). 5 is the device byte count and 6 the memory byte count. 7 is control/status. 8 is the completion-line address. Indices 3, 5 and 6 are read-only. Control bits: bit0 start (reads 0), bit1 stop, bit2 direction, bit3 active, bit4 error.
- R3: A control write with bit0 set while the engine is inactive makes it active. It then reads descriptors from the table pointer low, one after another, each four 32-bit words long. Each word is stored big-endian and is byte-reversed on fetch. Word1 is the buffer address. In word3, bit31 is end-of-list and bits 15:0 are the length in bytes.
- R4: With direction 0, the engine reads memory words at ascending addresses and emits each, in order, on the device output stream.
- R5: With direction 1, the engine takes words from the device input stream and writes them to memory at ascending addresses.
- R6: A length field of 0 means 65536 bytes. Bits 1:0 of the length are ignored.
- R7: Both byte counts clear at start. Each adds 4 for every word that crosses its own side. Register 3 ends at the address after the last data word.
- R8: Once the end-of-list descriptor is done, the engine writes 32 all-ones words to the completion line at ascending addresses. This happens after the last data write. The engine then becomes inactive.
- R9: A stop write while the engine is active reads back as bit1 = 1 until the engine halts. The engine halts at the next word boundary, never mid-request, and writes the completion line. Bit1 then reads 0. A stop write while the engine is inactive has no effect.
- R10: `mem_err` together with a grant sets the error bit, ends the transfer at once with no completion write, and clears the active bit. The error bit stays set until the next write to the control register.
- R11: While the engine is active, writes to the table pointer, completion address and direction are ignored, and so is a further start.
- R12: A memory request keeps its address, write flag and data stable until it is granted. The output stream holds valid and data until ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access completes in this cycle |
| mem_err | input | 1 | Access failed (valid with `mem_gnt`) |
| mem_rdata | input | 32 | Read data (valid with `mem_gnt`) |
| dev_in_valid | input | 1 | Device-to-memory stream valid |
| dev_in_data | input | 32 | Device-to-memory stream word |
| dev_in_ready | output | 1 | Engine accepts a device word |
| dev_out_valid | output | 1 | Memory-to-device stream valid |
| dev_out_data | output | 32 | Memory-to-device stream word |
| dev_out_ready | input | 1 | Device accepts the word |

## Verification
A memory-to-device run uses two descriptors in different regions. It separates correct descriptor chaining and byte reversal from a single-buffer walk, and the final address and counts show where the chain stopped. A device-to-memory run with a burst of register writes during the transfer shows that the direction path and the write-ignore rule work. A length-0 descriptor that is stopped after three words shows both the 65536-byte meaning (the engine is still active) and the halt-then-mark order. A poisoned read address shows the abort with no completion write and the sticky error. Grant and ready stall patterns throughout exercise the hold rules.

// File: rtl/ide_sg_dma_pkg.sv
package ide_sg_dma_pkg;

  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;
  localparam int LEN_W      = 17;

  // register word indices
  localparam logic [3:0] IDX_TIMING  = 4'd0;
  localparam logic [3:0] IDX_TBL_LO  = 4'd1;
  localparam logic [3:0] IDX_TBL_HI  = 4'd2;
  localparam logic [3:0] IDX_CUR     = 4'd3;
  localparam logic [3:0] IDX_ADR_HI  = 4'd4;
  localparam logic [3:0] IDX_CNT_DEV = 4'd5;
  localparam logic [3:0] IDX_CNT_MEM = 4'd6;
  localparam logic [3:0] IDX_CTRL    = 4'd7;
  localparam logic [3:0] IDX_DONE    = 4'd8;

  // control/status bit positions
  localparam int CB_START  = 0;
  localparam int CB_STOP   = 1;
  localparam int CB_DIR    = 2;
  localparam int CB_ACTIVE = 3;
  localparam int CB_ERR    = 4;

  // descriptor words that carry fields
  localparam logic [1:0] W_ADDR = 2'd1;
  localparam logic [1:0] W_LEN  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_BEAT,
    S_GET,
    S_PUT,
    S_DONE
  } eng_state_e;

endpackage

// File: rtl/idedma_desc_unpack.sv
module idedma_desc_unpack
  import ide_sg_dma_pkg::*;
(
  input  logic [WORD_W-1:0] raw_word,
  output logic [WORD_W-1:0] host_word,
  output logic [LEN_W-1:0]  len_bytes,
  output logic              last_flag
);

  // table words are stored big-endian: reverse byte lanes
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_swap
    assign host_word[8*b +: 8] = raw_word[8*(WORD_BYTES-1-b) +: 8];
  end

  assign last_flag = host_word[WORD_W-1];

  // zero length encodes the full 64 KiB window; sub-word bits dropped
  assign len_bytes = (host_word[15:0] == 16'h0000) ? LEN_W'(17'h10000)
                                                   : {1'b0, host_word[15:2], 2'b00};

endmodule

// File: rtl/idedma_regfile.sv
module idedma_regfile
  import ide_sg_dma_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_idx,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              active,
  input  logic              stop_pend,
  input  logic              err_flag,
  input  logic [WORD_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  cnt_dev,
  input  logic [CNT_W-1:0]  cnt_mem,
  output logic              start_req,
  output logic              stop_req,
  output logic              err_clr,
  output logic              dir_cfg,
  output logic [WORD_W-1:0] tbl_ptr,
  output logic [WORD_W-1:0] done_addr
);

  logic [WORD_W-1:0] timing_q, tbl_lo_q, tbl_hi_q, adr_hi_q, done_q;
  logic              dir_q;
  logic              cfg_en;
  logic              wr_timing, wr_tbl_lo, wr_tbl_hi, wr_adr_hi, wr_done, wr_ctrl;
  logic [WORD_W-1:0] ctrl_rd;

  assign cfg_en    = reg_wr && !active;
  assign wr_timing = cfg_en && (reg_idx == IDX_TIMING);
  assign wr_tbl_lo = cfg_en && (reg_idx == IDX_TBL_LO);
  assign wr_tbl_hi = cfg_en && (reg_idx == IDX_TBL_HI);
  assign wr_adr_hi = cfg_en && (reg_idx == IDX_ADR_HI);
  assign wr_done   = cfg_en && (reg_idx == IDX_DONE);
  assign wr_ctrl   = reg_wr && (reg_idx == IDX_CTRL);

  assign start_req = wr_ctrl && reg_wdata[CB_START] && !active;
  assign stop_req  = wr_ctrl && reg_wdata[CB_STOP];
  assign err_clr   = wr_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= '0;
      tbl_lo_q <= '0;
      tbl_hi_q <= '0;
      adr_hi_q <= '0;
      done_q   <= '0;
      dir_q    <= 1'b0;
    end else begin
      if (wr_timing) timing_q <= reg_wdata;
      if (wr_tbl_lo) tbl_lo_q <= reg_wdata;
      if (wr_tbl_hi) tbl_hi_q <= reg_wdata;
      if (wr_adr_hi) adr_hi_q <= reg_wdata;
      if (wr_done)   done_q   <= reg_wdata;
      if (wr_ctrl && !active) dir_q <= reg_wdata[CB_DIR];
    end
  end

  assign dir_cfg   = dir_q;
  assign tbl_ptr   = tbl_lo_q;
  assign done_addr = done_q;

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[CB_STOP]   = stop_pend;
    ctrl_rd[CB_DIR]    = dir_q;
    ctrl_rd[CB_ACTIVE] = active;
    ctrl_rd[CB_ERR]    = err_flag;
  end

  always_comb begin
    unique case (reg_idx)
      IDX_TIMING:  reg_rdata = timing_q;
      IDX_TBL_LO:  reg_rdata = tbl_lo_q;
      IDX_TBL_HI:  reg_rdata = tbl_hi_q;
      IDX_CUR:     reg_rdata = cur_addr;
      IDX_ADR_HI:  reg_rdata = adr_hi_q;
      IDX_CNT_DEV: reg_rdata = WORD_W'(cnt_dev);
      IDX_CNT_MEM: reg_rdata = WORD_W'(cnt_mem);
      IDX_CTRL:    reg_rdata = ctrl_rd;
      IDX_DONE:    reg_rdata = done_q;
      default:     reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/idedma_engine.sv
module idedma_engine
  import ide_sg_dma_pkg::*;
#(
  parameter int LINE_BYTES = 128,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              err_clr,
  input  logic              dir_cfg,
  input  logic [WORD_W-1:0] tbl_ptr,
  input  logic [WORD_W-1:0] done_addr,
  input  logic [WORD_W-1:0] desc_word,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_last,
  output logic              active,
  output logic              stop_pend,
  output logic              err_flag,
  output logic [WORD_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cnt_dev,
  output logic [CNT_W-1:0]  cnt_mem,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              dev_in_valid,
  input  logic [WORD_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [WORD_W-1:0] dev_out_data,
  input  logic              dev_out_ready
);

  localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES;
  localparam int LINE_IW    = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
  localparam logic [LINE_IW-1:0] LINE_LAST = LINE_IW'(LINE_WORDS - 1);

  eng_state_e         state_q, state_d;
  logic [1:0]         wsel_q, wsel_d;
  logic [WORD_W-1:0]  dptr_q, dptr_d;
  logic [WORD_W-1:0]  addr_q, addr_d;
  logic [LEN_W-1:0]   remain_q, remain_d;
  logic               eol_q, eol_d;
  logic [WORD_W-1:0]  hold_q, hold_d;
  logic [CNT_W-1:0]   bcd_q, bcd_d, bcm_q, bcm_d;
  logic [LINE_IW-1:0] line_q, line_d;
  logic               dir_q, dir_d;
  logic               err_q, err_d;
  logic               stop_q, stop_d;

  always_comb begin
    state_d  = state_q;
    wsel_d   = wsel_q;
    dptr_d   = dptr_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    eol_d    = eol_q;
    hold_d   = hold_q;
    bcd_d    = bcd_q;
    bcm_d    = bcm_q;
    line_d   = line_q;
    dir_d    = dir_q;
    err_d    = err_q;
    stop_d   = stop_q;

    mem_req       = 1'b0;
    mem_we        = 1'b0;
    mem_addr      = '0;
    mem_wdata     = '0;
    dev_in_ready  = 1'b0;
    dev_out_valid = 1'b0;

    if (err_clr) err_d = 1'b0;
    if (stop_req && (state_q != S_IDLE)) stop_d = 1'b1;

    unique case (state_q)
      S_IDLE: begin
        if (start_req) begin
          state_d  = S_FETCH;
          wsel_d   = 2'd0;
          dptr_d   = tbl_ptr;
          remain_d = '0;
          eol_d    = 1'b0;
          bcd_d    = '0;
          bcm_d    = '0;
          dir_d    = dir_cfg;
        end
      end

      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = dptr_q + WORD_W'({wsel_q, 2'b00});
        if (mem_gnt) begin
          if (mem_err) begin
            err_d   = 1'b1;
            state_d = S_IDLE;
          end else begin
            wsel_d = wsel_q + 2'd1;
            if (wsel_q == W_ADDR) addr_d = desc_word;
            if (wsel_q == W_LEN) begin
              remain_d = desc_len;
              eol_d    = desc_last;
              dptr_d   = dptr_q + WORD_W'(DESC_BYTES);
              state_d  = S_BEAT;
            end
          end
        end
      end

      S_BEAT: begin
        if (stop_q) begin
          state_d = S_DONE;
          line_d  = '0;
        end else if (remain_q == '0) begin
          if (eol_q) begin
            state_d = S_DONE;
            line_d  = '0;
          end else begin
            state_d = S_FETCH;
            wsel_d  = 2'd0;
          end
        end else begin
          state_d = S_GET;
        end
      end

      S_GET: begin
        if (dir_q) begin
          if (stop_q) begin
            state_d = S_DONE;
            line_d  = '0;
          end else begin
            dev_in_ready = 1'b1;
            if (dev_in_valid) begin
              hold_d  = dev_in_data;
              bcd_d   = bcd_q + CNT_W'(WORD_BYTES);
              state_d = S_PUT;
            end
          end
        end else begin
          mem_req  = 1'b1;
          mem_addr = addr_q;
          if (mem_gnt) begin
            if (mem_err) begin
              err_d   = 1'b1;
              state_d = S_IDLE;
            end else begin
              hold_d  = mem_rdata;
              bcm_d   = bcm_q + CNT_W'(WORD_BYTES);
              state_d = S_PUT;
            end
          end
        end
      end

      S_PUT: begin
        if (dir_q) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = addr_q;
          mem_wdata = hold_q;
          if (mem_gnt) begin
            if (mem_err) begin
              err_d   = 1'b1;
              state_d = S_IDLE;
            end else begin
              bcm_d    = bcm_q + CNT_W'(WORD_BYTES);
              addr_d   = addr_q + WORD_W'(WORD_BYTES);
              remain_d = remain_q - LEN_W'(WORD_BYTES);
              state_d  = S_BEAT;
            end
          end
        end else begin
          dev_out_valid = 1'b1;
          if (dev_out_ready) begin
            bcd_d    = bcd_q + CNT_W'(WORD_BYTES);
            addr_d   = addr_q + WORD_W'(WORD_BYTES);
            remain_d = remain_q - LEN_W'(WORD_BYTES);
            state_d  = S_BEAT;
          end
        end
      end

      S_DONE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = done_addr + WORD_W'({line_q, 2'b00});
        mem_wdata = '1;
        if (mem_gnt) begin
          if (mem_err) begin
            err_d   = 1'b1;
            state_d = S_IDLE;
          end else if (line_q == LINE_LAST) begin
            state_d = S_IDLE;
          end else begin
            line_d = line_q + LINE_IW'(1);
          end
        end
      end

      default: state_d = S_IDLE;
    endcase

    if (state_d == S_IDLE) stop_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      wsel_q   <= '0;
      dptr_q   <= '0;
      addr_q   <= '0;
      remain_q <= '0;
      eol_q    <= 1'b0;
      hold_q   <= '0;
      bcd_q    <= '0;
      bcm_q    <= '0;
      line_q   <= '0;
      dir_q    <= 1'b0;
      err_q    <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      wsel_q   <= wsel_d;
      dptr_q   <= dptr_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      eol_q    <= eol_d;
      hold_q   <= hold_d;
      bcd_q    <= bcd_d;
      bcm_q    <= bcm_d;
      line_q   <= line_d;
      dir_q    <= dir_d;
      err_q    <= err_d;
      stop_q   <= stop_d;
    end
  end

  assign active       = (state_q != S_IDLE);
  assign stop_pend    = stop_q;
  assign err_flag     = err_q;
  assign cur_addr     = addr_q;
  assign cnt_dev      = bcd_q;
  assign cnt_mem      = bcm_q;
  assign dev_out_data = hold_q;

endmodule

// File: rtl/ide_sg_dma.sv
module ide_sg_dma
  import ide_sg_dma_pkg::*;
#(
  parameter int LINE_BYTES = 128,
  parameter int CNT_W      = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  input  logic        dev_in_valid,
  input  logic [31:0] dev_in_data,
  output logic        dev_in_ready,
  output logic        dev_out_valid,
  output logic [31:0] dev_out_data,
  input  logic        dev_out_ready
);

  logic              eng_active, eng_stop, eng_err;
  logic              start_req, stop_req, err_clr, dir_cfg;
  logic [WORD_W-1:0] tbl_ptr, done_addr, cur_addr;
  logic [CNT_W-1:0]  cnt_dev, cnt_mem;
  logic [WORD_W-1:0] desc_word;
  logic [LEN_W-1:0]  desc_len;
  logic              desc_last;

  idedma_regfile #(.CNT_W(CNT_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .active    (eng_active),
    .stop_pend (eng_stop),
    .err_flag  (eng_err),
    .cur_addr  (cur_addr),
    .cnt_dev   (cnt_dev),
    .cnt_mem   (cnt_mem),
    .start_req (start_req),
    .stop_req  (stop_req),
    .err_clr   (err_clr),
    .dir_cfg   (dir_cfg),
    .tbl_ptr   (tbl_ptr),
    .done_addr (done_addr)
  );

  idedma_desc_unpack unpack_i (
    .raw_word  (mem_rdata),
    .host_word (desc_word),
    .len_bytes (desc_len),
    .last_flag (desc_last)
  );

  idedma_engine #(.LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)) eng_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .err_clr       (err_clr),
    .dir_cfg       (dir_cfg),
    .tbl_ptr       (tbl_ptr),
    .done_addr     (done_addr),
    .desc_word     (desc_word),
    .desc_len      (desc_len),
    .desc_last     (desc_last),
    .active        (eng_active),
    .stop_pend     (eng_stop),
    .err_flag      (eng_err),
    .cur_addr      (cur_addr),
    .cnt_dev       (cnt_dev),
    .cnt_mem       (cnt_mem),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_gnt       (mem_gnt),
    .mem_err       (mem_err),
    .mem_rdata     (mem_rdata),
    .dev_in_valid  (dev_in_valid),
    .dev_in_data   (dev_in_data),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid),
    .dev_out_data  (dev_out_data),
    .dev_out_ready (dev_out_ready)
  );

endmodule

// File: rtl/ide_sg_dma_chk.sv
module ide_sg_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:0]  reg_idx,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_gnt,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        dev_in_ready,
  input logic        dev_out_valid,
  input logic        dev_out_ready,
  input logic [31:0] dev_out_data,
  input logic        eng_active,
  input logic        eng_stop,
  input logic        eng_err
);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_active |-> (!mem_req && !dev_in_ready && !dev_out_valid));

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 4'd7 && reg_wdata[0] && !eng_active) |=> eng_active);

  // R9
  stop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop |-> eng_active);

  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |-> !eng_active);

  // R4
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_in_ready && dev_out_valid));

endmodule

bind ide_sg_dma ide_sg_dma_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_idx       (reg_idx),
  .reg_wdata     (reg_wdata),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_gnt       (mem_gnt),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .dev_in_ready  (dev_in_ready),
  .dev_out_valid (dev_out_valid),
  .dev_out_ready (dev_out_ready),
  .dev_out_data  (dev_out_data),
  .eng_active    (eng_active),
  .eng_stop      (eng_stop),
  .eng_err       (eng_err)
);

// File: tb/ide_sg_dma_tb_top.sv
module ide_sg_dma_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_idx = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_in_valid, dev_in_ready, dev_out_valid, dev_out_ready;
  logic [31:0] dev_in_data, dev_out_data;

  always #5 clk = ~clk;

  ide_sg_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model with stall pattern
  logic [31:0] mem [0:1023];
  int unsigned tick = 0;
  logic        tb_we = 1'b0;
  logic [9:0]  tb_wa = '0;
  logic [31:0] tb_wd = '0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;

  always @(posedge clk) begin
    tick <= tick + 1;
    if (tb_we) mem[tb_wa] <= tb_wd;
    else if (mem_req && mem_we && mem_gnt) mem[mem_addr[11:2]] <= mem_wdata;
  end

  assign mem_gnt       = mem_req && (tick[1:0] != 2'd3);
  assign mem_err       = mem_gnt && err_en && (mem_addr == err_addr);
  assign mem_rdata     = mem[mem_addr[11:2]];
  assign dev_out_ready = (tick[2:0] != 3'd5);

  // device source stream
  logic [31:0] src_arr [0:63];
  int src_cnt = 0;
  int src_idx = 0;
  assign dev_in_valid = (src_idx < src_cnt) && tick[0];
  assign dev_in_data  = src_arr[src_idx[5:0]];
  always @(posedge clk) if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;

  // scoreboard queues
  logic [63:0] exp_wr_q [$];
  logic [31:0] exp_out_q [$];
  logic        pend_v = 1'b0;
  logic [31:0] pend_a = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_v) chk("R12", "held request address", {31'd0, mem_req, mem_addr}, {32'd1, pend_a});
      pend_v <= mem_req && !mem_gnt;
      pend_a <= mem_addr;
      if (mem_req && mem_we && mem_gnt) begin
        if (exp_wr_q.size() == 0) chk("R5/R8", "unexpected memory write", {mem_addr, mem_wdata}, 64'd0);
        else chk("R5/R8", "memory write", {mem_addr, mem_wdata}, exp_wr_q.pop_front());
      end
      if (dev_out_valid && dev_out_ready) begin
        if (exp_out_q.size() == 0) chk("R4", "unexpected stream word", {32'd0, dev_out_data}, 64'd0);
        else chk("R4", "stream word", {32'd0, dev_out_data}, {32'd0, exp_out_q.pop_front()});
      end
    end
  end

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic mem_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_wa = a[11:2]; tb_wd = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] a,
                          input logic [15:0] len, input logic last);
    mem_wr(base,      32'd0);
    mem_wr(base + 4,  bsw(a));
    mem_wr(base + 8,  32'd0);
    mem_wr(base + 12, bsw({last, 15'd0, len}));
  endtask

  task automatic reg_write(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] i, output logic [31:0] d);
    @(negedge clk); reg_idx = i; #1 d = reg_rdata;
  endtask

  task automatic start_dma();
    logic [31:0] c;
    reg_read(4'd7, c);
    reg_write(4'd7, c | 32'h1);
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    int n = 0;
    do begin reg_read(4'd7, c); n++; end while (c[3] && n < 5000);
  endtask

  task automatic exp_done(input logic [31:0] a);
    for (int k = 0; k < 32; k++) exp_wr_q.push_back({a + 32'(4 * k), 32'hFFFF_FFFF});
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk("WDOG", "run did not finish", 64'd1, 64'd0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 9; i++) begin
      reg_read(4'(i), v);
      chk("R1", "register after reset", {32'd0, v}, 64'd0);
    end
    chk("R1", "idle outputs", {61'd0, mem_req, dev_out_valid, dev_in_ready}, 64'd0);

    // R9 stop while idle has no effect
    reg_write(4'd7, 32'h2);
    reg_read(4'd7, v);
    chk("R9", "stop while idle", {32'd0, v}, 64'd0);

    // Test A: memory to device, two chained descriptors (R3 R4 R7 R8)
    mem_wr(32'h400, 32'hA000_0001); mem_wr(32'h404, 32'hA000_0002);
    mem_wr(32'h500, 32'hB000_0001); mem_wr(32'h504, 32'hB000_0002);
    mem_wr(32'h508, 32'hB000_0003);
    put_desc(32'h100, 32'h400, 16'd8, 1'b0);
    put_desc(32'h110, 32'h500, 16'd12, 1'b1);
    exp_out_q.push_back(32'hA000_0001); exp_out_q.push_back(32'hA000_0002);
    exp_out_q.push_back(32'hB000_0001); exp_out_q.push_back(32'hB000_0002);
    exp_out_q.push_back(32'hB000_0003);
    exp_done(32'hC00);
    reg_write(4'd1, 32'h100);
    reg_write(4'd8, 32'hC00);
    reg_write(4'd7, 32'h0);
    start_dma();
    wait_idle();
    chk("R4", "stream words left", 64'(exp_out_q.size()), 64'd0);
    chk("R8", "completion words left", 64'(exp_wr_q.size()), 64'd0);
    reg_read(4'd5, v); chk("R7", "device count A", {32'd0, v}, 64'd20);
    reg_read(4'd6, v); chk("R7", "memory count A", {32'd0, v}, 64'd20);
    reg_read(4'd3, v); chk("R7", "end address A", {32'd0, v}, 64'h50C);
    reg_read(4'd7, v); chk("R8", "inactive after A", {32'd0, v}, 64'd0);

    // Test B: device to memory, writes ignored while active (R2 R5 R11)
    put_desc(32'h140, 32'h600, 16'd16, 1'b1);
    for (int i = 0; i < 4; i++) begin
      src_arr[src_cnt] = 32'hD000_0010 + 32'(i);
      exp_wr_q.push_back({32'h600 + 32'(4 * i), 32'hD000_0010 + 32'(i)});
      src_cnt++;
    end
    exp_done(32'hC80);
    reg_write(4'd1, 32'h140);
    reg_write(4'd8, 32'hC80);
    reg_write(4'd7, 32'h4);
    reg_read(4'd7, v); chk("R2", "direction bit position", {32'd0, v}, 64'h4);
    start_dma();
    reg_write(4'd1, 32'h3F0);
    reg_write(4'd8, 32'h000);
    reg_write(4'd7, 32'h1);
    reg_read(4'd1, v); chk("R11", "table pointer kept", {32'd0, v}, 64'h140);
    reg_read(4'd8, v); chk("R11", "completion address kept", {32'd0, v}, 64'hC80);
    wait_idle();
    chk("R5", "writes left", 64'(exp_wr_q.size()), 64'd0);
    reg_read(4'd5, v); chk("R7", "device count B", {32'd0, v}, 64'd16);
    reg_read(4'd6, v); chk("R7", "memory count B", {32'd0, v}, 64'd16);
    reg_read(4'd7, v); chk("R11", "direction kept, inactive", {32'd0, v}, 64'h4);

    // Test C: zero length = 64 KiB, stopped after three words (R6 R9)
    put_desc(32'h180, 32'h800, 16'd0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      src_arr[src_cnt] = 32'hE000_0020 + 32'(i);
      exp_wr_q.push_back({32'h800 + 32'(4 * i), 32'hE000_0020 + 32'(i)});
      src_cnt++;
    end
    exp_done(32'hD00);
    reg_write(4'd1, 32'h180);
    reg_write(4'd8, 32'hD00);
    start_dma();
    begin
      int n = 0;
      do begin reg_read(4'd6, v); n++; end while (v != 32'd12 && n < 2000);
    end
    reg_read(4'd7, v); chk("R6", "still active after 12 bytes", {63'd0, v[3]}, 64'd1);
    reg_write(4'd7, 32'h6);
    reg_read(4'd7, v); chk("R9", "stop reads 1 while halting", {63'd0, v[1]}, 64'd1);
    wait_idle();
    reg_read(4'd7, v); chk("R9", "stop self-clears", {32'd0, v}, 64'h4);
    chk("R9", "completion after stop", 64'(exp_wr_q.size()), 64'd0);
    reg_read(4'd5, v); chk("R7", "device count C", {32'd0, v}, 64'd12);
    reg_read(4'd6, v); chk("R7", "memory count C", {32'd0, v}, 64'd12);

    // Test D: memory error aborts, sticky flag (R10)
    mem_wr(32'h700, 32'hF000_0001);
    mem_wr(32'h704, 32'hF000_0002);
    put_desc(32'h1C0, 32'h700, 16'd8, 1'b1);
    exp_out_q.push_back(32'hF000_0001);
    err_addr = 32'h704;
    err_en = 1'b1;
    reg_write(4'd1, 32'h1C0);
    reg_write(4'd8, 32'hE00);
    reg_write(4'd7, 32'h0);
    start_dma();
    wait_idle();
    err_en = 1'b0;
    repeat (4) @(negedge clk);
    reg_read(4'd7, v); chk("R10", "error set, inactive", {32'd0, v}, 64'h10);
    chk("R10", "no completion, no extra words", 64'(exp_wr_q.size() + exp_out_q.size()), 64'd0);
    reg_read(4'd5, v); chk("R10", "device count at abort", {32'd0, v}, 64'd4);
    reg_read(4'd6, v); chk("R10", "memory count at abort", {32'd0, v}, 64'd4);
    reg_write(4'd0, 32'h55);
    reg_read(4'd7, v); chk("R10", "error sticky over other writes", {32'd0, v}, 64'h10);
    reg_write(4'd7, 32'h0);
    reg_read(4'd7, v); chk("R10", "error cleared by control write", {32'd0, v}, 64'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule